// File: doc/BRIEF.md
# Dual-Slope Converter Sequencer

This block is the digital control core of an integrating converter that works by timing two integration phases. On a start request it first discharges the integrator and then connects the unknown input for a fixed number of clock cycles. It then switches the integrator to a reference of opposite polarity and counts clock cycles until the comparator reports that the integrator is back at its starting level. The integrator's resistance and capacitance act the same way in both phases, so they cancel. The count of the second phase is therefore proportional to the ratio of input to reference, scaled by the fixed first interval, and no calibration constant is needed.

The block drives three switch controls: discharge, input select and reference select. At most one of them is active at any time, and all are off while idle. The comparator output reaches the block through a synchronizer chain. The result is a count of RES_BITS+1 bits, which leaves room to detect overrange. When a conversion ends, the result and an overrange flag are updated and a done flag pulses for one cycle.

Top module: `dslope_seq`

## Requirements
- R1: After reset, result_o is 0, ovr_o and done_o are low and all three switch outputs are low.
- R2: A start_i sampled high while idle starts a conversion. sw_rst_o goes high in the next cycle and stays high for exactly RESET_CYCLES cycles.
- R3: sw_in_o goes high in the cycle right after the discharge phase and stays high for exactly T1_CYCLES cycles.
- R4: sw_ref_o goes high in the cycle right after the input phase. It stays high until the reference phase ends, and the phases never return to an earlier one or leave a gap.
- R5: cmp_i passes through SYNC_STAGES flops. Number the rising edges of the reference phase so that the edge ending its first cycle is edge 1. If cmp_i is first sampled high at edge m, result_o = m + SYNC_STAGES - 1 and sw_ref_o is high for result_o + 1 cycles. If the synchronized comparator is already high in the first reference cycle, result_o = 0.
- R6: If the synchronized comparator is still low in reference cycle 2^(RES_BITS+1)-1, the conversion aborts. result_o saturates to all ones, ovr_o is set, and sw_ref_o has been high for 2^(RES_BITS+1) cycles.
- R7: done_o is high for exactly one cycle, the cycle right after the last reference cycle. result_o and ovr_o change only together with done_o and hold their values until the next done_o.
- R8: A start_i pulse during an active conversion has no effect on the length of any phase.
- R9: At most one of sw_rst_o, sw_in_o and sw_ref_o is high in any cycle, and none is high while idle.
- R10: A comparator crossing seen in the last allowed reference cycle wins over the abort. result_o is then all ones and ovr_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Conversion request, sampled while idle |
| cmp_i | input | 1 | Comparator output, high once the integrator is back at its start level (asynchronous) |
| sw_rst_o | output | 1 | Integrator discharge switch |
| sw_in_o | output | 1 | Input select switch |
| sw_ref_o | output | 1 | Reference select switch |
| result_o | output | RES_BITS+1 | Reference-phase count |
| done_o | output | 1 | One-cycle pulse when the result is updated |
| ovr_o | output | 1 | Overrange flag of the last conversion |

## Verification
A behavioural integrator in the bench ramps up by the input amount in each input cycle and down by the reference amount in each reference cycle, and raises the comparator once its level is no longer positive. Random input and reference pairs check that the count tracks the ratio of the two. A zero input checks the path where the comparator is already high when the reference phase starts. Two directed inputs sit on either side of the terminal count, telling a crossing in the last cycle (R10) apart from a true abort (R6). A conversion with a start pulse in the middle of its input phase shows whether a restart could shorten or stretch a phase.

// File: rtl/dslope_pkg.sv
package dslope_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_CLR  = 2'd1,
      PH_INT  = 2'd2,
      PH_REF  = 2'd3
   } phase_e;
endpackage

// File: rtl/dslope_sync.sv
module dslope_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/dslope_cnt.sv
module dslope_cnt #(
   parameter int W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         en_i,
   output logic [W-1:0] cnt_o
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clr_i) cnt_q <= '0;
      else if (en_i)  cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;

   // R6: the sequencer must leave the phase before the counter could wrap
   a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !clr_i) |-> !(&cnt_q));
endmodule

// File: rtl/dslope_fsm.sv
module dslope_fsm
   import dslope_pkg::*;
#(
   parameter int RES_BITS     = 8,
   parameter int T1_CYCLES    = 256,
   parameter int RESET_CYCLES = 4,
   parameter int CNT_W        = RES_BITS + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             cmp_s_i,
   input  logic [CNT_W-1:0] cnt_i,
   output phase_e           phase_o,
   output logic             cnt_clr_o,
   output logic             cnt_en_o,
   output logic [CNT_W-1:0] result_o,
   output logic             done_o,
   output logic             ovr_o
);
   localparam logic [CNT_W-1:0] CLR_LAST = CNT_W'(RESET_CYCLES - 1);
   localparam logic [CNT_W-1:0] INT_LAST = CNT_W'(T1_CYCLES - 1);
   localparam logic [CNT_W-1:0] CNT_TOP  = {CNT_W{1'b1}};

   phase_e ph_q, ph_d;
   logic   finish;

   always_comb begin
      ph_d = ph_q;
      unique case (ph_q)
         PH_IDLE: if (start_i)                      ph_d = PH_CLR;
         PH_CLR:  if (cnt_i == CLR_LAST)            ph_d = PH_INT;
         PH_INT:  if (cnt_i == INT_LAST)            ph_d = PH_REF;
         PH_REF:  if (cmp_s_i || cnt_i == CNT_TOP)  ph_d = PH_IDLE;
         default:                                   ph_d = PH_IDLE;
      endcase
   end

   assign finish    = (ph_q == PH_REF) && (ph_d == PH_IDLE);
   assign cnt_clr_o = (ph_d != ph_q) || (ph_q == PH_IDLE);
   assign cnt_en_o  = !cnt_clr_o;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q     <= PH_IDLE;
         done_o   <= 1'b0;
         result_o <= '0;
         ovr_o    <= 1'b0;
      end else begin
         ph_q   <= ph_d;
         done_o <= finish;
         if (finish) begin
            result_o <= cmp_s_i ? cnt_i : CNT_TOP;
            ovr_o    <= !cmp_s_i;
         end
      end
   end

   assign phase_o = ph_q;

   // R7: result and flag move only with the done pulse
   a_r7_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(result_o) && $stable(ovr_o));
   // R10: a crossing in the last reference cycle is not an overrange
   a_r10_cmp_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_REF && cmp_s_i) |=> done_o && !ovr_o);
endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
   import dslope_pkg::*;
#(
   parameter int RES_BITS     = 8,
   parameter int T1_CYCLES    = 2 ** RES_BITS,
   parameter int RESET_CYCLES = 4,
   parameter int SYNC_STAGES  = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic                cmp_i,
   output logic                sw_rst_o,
   output logic                sw_in_o,
   output logic                sw_ref_o,
   output logic [RES_BITS:0]   result_o,
   output logic                done_o,
   output logic                ovr_o
);
   localparam int CNT_W   = RES_BITS + 1;
   localparam int CNT_LIM = 2 ** CNT_W;

   generate
      if (RES_BITS < 1 || RES_BITS > 30) begin : g_bad_bits
         $error("dslope_seq: RES_BITS out of range");
      end
      if (T1_CYCLES < SYNC_STAGES || T1_CYCLES > CNT_LIM) begin : g_bad_t1
         $error("dslope_seq: T1_CYCLES must cover the synchronizer and fit the counter");
      end
      if (RESET_CYCLES < 1 || RESET_CYCLES > CNT_LIM) begin : g_bad_rst
         $error("dslope_seq: RESET_CYCLES out of range");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("dslope_seq: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic             cmp_s;
   logic             cnt_clr, cnt_en;
   logic [CNT_W-1:0] cnt;
   phase_e           phase;

   dslope_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (cmp_i),
      .q_o   (cmp_s)
   );

   dslope_cnt #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (cnt_clr),
      .en_i  (cnt_en),
      .cnt_o (cnt)
   );

   dslope_fsm #(
      .RES_BITS     (RES_BITS),
      .T1_CYCLES    (T1_CYCLES),
      .RESET_CYCLES (RESET_CYCLES),
      .CNT_W        (CNT_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .cmp_s_i   (cmp_s),
      .cnt_i     (cnt),
      .phase_o   (phase),
      .cnt_clr_o (cnt_clr),
      .cnt_en_o  (cnt_en),
      .result_o  (result_o),
      .done_o    (done_o),
      .ovr_o     (ovr_o)
   );

   assign sw_rst_o = (phase == PH_CLR);
   assign sw_in_o  = (phase == PH_INT);
   assign sw_ref_o = (phase == PH_REF);

   // R9: never two switches at once
   a_r9_one_switch: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sw_rst_o, sw_in_o, sw_ref_o}));
   // R2: discharge only starts from idle
   a_r2_clr_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw_rst_o) |-> $past({sw_rst_o, sw_in_o, sw_ref_o}) == 3'b000);
   // R3: input phase follows discharge and lasts T1 cycles
   a_r3_in_after_clr: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw_in_o) |-> $past(sw_rst_o));
   a_r3_in_length: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sw_in_o) |-> $past(cnt) == CNT_W'(T1_CYCLES - 1));
   // R4: reference phase follows the input phase
   a_r4_ref_after_in: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw_ref_o) |-> $past(sw_in_o));
   // R7: done is a single-cycle pulse right after the reference phase
   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   a_r7_done_after_ref: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(sw_ref_o) && !sw_ref_o);
   // R6: an abort saturates the result
   a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && ovr_o) |-> &result_o);
   // R8: a start during a conversion does not restart it
   a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      ((sw_in_o || sw_ref_o) && start_i) |=> !sw_rst_o);
endmodule

// File: tb/dslope_seq_tb.sv
module dslope_seq_tb;
   localparam int RB   = 8;
   localparam int T1   = 256;
   localparam int RC   = 4;
   localparam int SS   = 2;
   localparam int MAXV = 2 ** (RB + 1) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          cmp_i = 1'b1;
   logic          sw_rst_o, sw_in_o, sw_ref_o, done_o, ovr_o;
   logic [RB:0]   result_o;

   int checks = 0;
   int fails  = 0;
   int vin_cur = 0;
   int vref_cur = 100;
   int lvl = 0;

   always #10 clk = ~clk;

   dslope_seq #(.RES_BITS(RB), .T1_CYCLES(T1), .RESET_CYCLES(RC), .SYNC_STAGES(SS)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
      .sw_rst_o(sw_rst_o), .sw_in_o(sw_in_o), .sw_ref_o(sw_ref_o),
      .result_o(result_o), .done_o(done_o), .ovr_o(ovr_o)
   );

   // behavioural integrator and comparator
   always @(negedge clk) begin
      if (sw_rst_o)      lvl = 0;
      else if (sw_in_o)  lvl = lvl + vin_cur;
      else if (sw_ref_o) lvl = lvl - vref_cur;
      cmp_i <= (lvl <= 0);
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int raw_count(input int vin, input int vref);
      if (vin == 0) return 0;
      return (T1 * vin + vref - 1) / vref + SS - 1;
   endfunction

   function automatic int exp_res(input int vin, input int vref);
      int e = raw_count(vin, vref);
      return (e > MAXV) ? MAXV : e;
   endfunction

   task automatic convert(input int vin, input int vref, input bit poke);
      int n_rst = 0, n_in = 0, n_ref = 0, prev = 0, guard = 0;
      bit order_ok = 1, one_ok = 1;
      int er, eo;
      logic [RB:0] held;
      vin_cur  = vin;
      vref_cur = vref;
      er = exp_res(vin, vref);
      eo = (raw_count(vin, vref) > MAXV) ? 1 : 0;
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      while (!done_o && guard < 3000) begin
         int cur;
         cur = sw_rst_o ? 1 : sw_in_o ? 2 : sw_ref_o ? 3 : 0;
         if ((sw_rst_o + sw_in_o + sw_ref_o) > 1) one_ok = 0;
         if (cur == 0 || cur < prev) order_ok = 0;
         prev = cur;
         if (sw_rst_o) n_rst++;
         if (sw_in_o)  n_in++;
         if (sw_ref_o) n_ref++;
         start_i = (poke && sw_in_o && n_in == 10) ? 1'b1 : 1'b0;
         @(negedge clk);
         guard++;
      end
      start_i = 1'b0;
      chk(done_o, "R7 done seen", done_o, 1);
      chk(n_rst == RC, poke ? "R8 discharge length" : "R2 discharge length", n_rst, RC);
      chk(n_in == T1, poke ? "R8 input length" : "R3 input length", n_in, T1);
      chk(order_ok, "R4 phase order", order_ok, 1);
      chk(one_ok, "R9 one switch", one_ok, 1);
      chk(n_ref == er + 1, "R4 reference length", n_ref, er + 1);
      chk(result_o == er[RB:0], eo ? "R6 saturated result" : "R5 result", result_o, er);
      chk(ovr_o == eo[0], eo ? "R6 overrange flag" : "R10 overrange flag", ovr_o, eo);
      held = result_o;
      @(negedge clk);
      chk(!done_o, "R7 done one cycle", done_o, 0);
      chk(!(sw_rst_o | sw_in_o | sw_ref_o), "R9 idle switches off", {sw_rst_o, sw_in_o, sw_ref_o}, 0);
      repeat (3) @(negedge clk);
      chk(result_o == held, "R7 result held", result_o, held);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240519));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(result_o == 0, "R1 reset result", result_o, 0);
      chk(!done_o && !ovr_o, "R1 reset flags", {done_o, ovr_o}, 0);
      chk(!(sw_rst_o | sw_in_o | sw_ref_o), "R1 reset switches", {sw_rst_o, sw_in_o, sw_ref_o}, 0);
      convert(0, 100, 0);     // R5 comparator already high
      convert(1, 100, 0);     // R5 small input
      convert(100, 100, 0);   // R5 equal input and reference
      convert(255, 128, 0);   // R10 crossing in the last cycle
      convert(256, 128, 0);   // R6 one step past the top
      convert(300, 100, 0);   // R6 deep overrange
      convert(50, 100, 0);    // R7 flag cleared again
      convert(70, 90, 1);     // R8 start during conversion
      for (int i = 0; i < 20; i++) begin
         int vr = 60 + int'($urandom % 81);
         int vi = int'($urandom % (2 * vr + 10));
         convert(vi, vr, (i % 5) == 0);
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule